// File: doc/BRIEF.md
# Paired Load/Store Micro-Op Cracker

This block sits between an instruction decoder and the issue logic of a processor core. It takes one decoded paired load or store, which moves two registers to or from adjacent memory, and breaks it into a short ordered run of micro-op descriptors. It emits one descriptor per cycle over a valid/ready handshake. Every sequence starts with an address-generation step that forms a temporary address from the base register and the immediate. One or more memory steps follow, each addressing memory relative to that temporary. A base-update step closes the sequence when the addressing mode asks for writeback.

The memory steps depend on the register width. A 16-byte register moves as a bottom half and a top half. Two 8-byte registers move as two separate accesses. Two 4-byte registers merge into one dual-register access, and an integer load of that kind picks a sign-extending or zero-extending form.

The final descriptor is marked last and every earlier one is marked delayed-commit, so the downstream pipeline retires the sequence as a unit. A size encoding the block cannot crack is consumed at once: it raises a one-cycle error flag and produces no micro-ops.

Top module: `pair_cracker`

## Requirements
- R1: `inReady` is high exactly when no sequence is in flight (after reset and once a sequence has drained). An accepted valid descriptor shows its first micro-op on the outputs in the cycle after the accepting edge, with `inReady` low while it is in flight.
- R2: A valid descriptor yields 1 + size/4 micro-ops, plus one more when `inMode` is pre-index (1) or post-index (2). Modes 0 and 3 both mean plain offset with no writeback. After the last handshake `outValid` is low.
- R3: Micro-op 0 has opcode ADDR (0), `outRegA` = base, and `outImm` = the immediate, or 0 in post-index mode.
- R4: For size 16 the memory steps are, in order: bottom half of the first register at offset 0, top half of the first at offset 0, bottom half of the second at offset 16, top half of the second at offset 16. Loads use opcodes 3 (bottom) and 4 (top); stores use 5 (bottom) and 6 (top).
- R5: For size 8 there are two memory steps: the first register at offset 0, then the second at offset 8. Loads use opcode 1 and stores use opcode 2.
- R6: For size 4 there is one dual step at offset 0, with `outRegA` = first register and `outRegB` = second register. An integer load with sign-extend set uses opcode 7. Any other load uses opcode 8, so sign-extend is ignored for floating-point. A store uses opcode 9.
- R7: With writeback, the final micro-op has opcode WB (10), `outRegA` = base, and `outImm` = the immediate in post-index mode, else 0.
- R8: The final micro-op has `outLast`=1 and `outDelayed`=0. Every earlier one has `outLast`=0 and `outDelayed`=1.
- R9: `outBaseSp` is 1 on ADDR and WB micro-ops when the base index is 31, which denotes the stack pointer. It is 0 on every other micro-op.
- R10: While `outValid` is high and `outReady` is low, every output field holds its value.
- R11: A descriptor whose size is not 4, 8 or 16 is accepted, raises `sizeErr` for exactly the following cycle, and emits no micro-op.
- R12: `outFp` equals the floating-point flag on memory micro-ops and is 0 on ADDR and WB. On memory micro-ops `outImm` is 0 and, except for dual steps, `outRegB` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Macro-instruction descriptor valid |
| inReady | output | 1 | Block can accept a descriptor |
| inSize | input | 5 | Bytes per register (4, 8 or 16) |
| inFp | input | 1 | Floating-point register pair |
| inLoad | input | 1 | 1 = load, 0 = store |
| inSignExt | input | 1 | Sign-extend request for 4-byte integer loads |
| inMode | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 offset |
| inImm | input | IMM_W | Signed immediate |
| inBase | input | REG_W | Base register index (31 = stack pointer) |
| inRegA | input | REG_W | First data register |
| inRegB | input | REG_W | Second data register |
| outValid | output | 1 | Micro-op valid |
| outReady | input | 1 | Consumer takes the micro-op |
| outOp | output | 4 | Micro-op opcode class |
| outRegA | output | REG_W | Data register, or base for ADDR/WB |
| outRegB | output | REG_W | Second register of a dual step |
| outOffset | output | OFF_W | Byte offset from the temporary address |
| outImm | output | IMM_W | Immediate of ADDR/WB steps |
| outFp | output | 1 | Floating-point memory step |
| outBaseSp | output | 1 | Base is the stack pointer (ADDR/WB) |
| outLast | output | 1 | Final micro-op of the sequence |
| outDelayed | output | 1 | Delayed-commit marker |
| sizeErr | output | 1 | One-cycle flag for an unsupported size |

## Verification
The bench builds the block with its default parameters: 5-bit register indices, a 12-bit immediate and an 8-bit offset. At these widths every combination of size, floating-point flag, direction, sign-extend and all four mode codes can be swept, each with a positive and a negative immediate and with the base alternately 31 and an ordinary register. The sweep covers all micro-op orderings, both immediate placements and the stack-pointer flag. Every one of the 32 size codes is also tried, which covers the error path. Output stalls are inserted at varying steps to check that the outputs hold during backpressure.

// File: rtl/pair_cracker_pkg.sv
package pair_cracker_pkg;
  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    OP_ADDR      = 4'd0,
    OP_LOAD      = 4'd1,
    OP_STORE     = 4'd2,
    OP_LOAD_LO   = 4'd3,
    OP_LOAD_HI   = 4'd4,
    OP_STORE_LO  = 4'd5,
    OP_STORE_HI  = 4'd6,
    OP_LOAD2_SX  = 4'd7,
    OP_LOAD2_ZX  = 4'd8,
    OP_STORE2    = 4'd9,
    OP_WB        = 4'd10
  } uop_e;

  localparam logic [1:0] MODE_PRE  = 2'd1;
  localparam logic [1:0] MODE_POST = 2'd2;

  typedef struct packed {
    logic              capture;
    logic              isLast;
    logic [STEP_W-1:0] step;
  } ctl_s;
endpackage

// File: rtl/pair_cracker_ctrl.sv
module pair_cracker_ctrl
  import pair_cracker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [4:0] inSize,
  input  logic [1:0] inMode,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       sizeErr,
  output ctl_s       ctl
);
  logic              busy;
  logic [STEP_W-1:0] stepQ;
  logic [STEP_W-1:0] lastIdxQ;
  logic              badSize;
  logic              wantWb;
  logic              acceptOk;

  assign badSize  = !(inSize == 5'd4 || inSize == 5'd8 || inSize == 5'd16);
  assign wantWb   = (inMode == MODE_PRE) || (inMode == MODE_POST);
  assign acceptOk = inValid && !busy && !badSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      stepQ    <= '0;
      lastIdxQ <= '0;
      sizeErr  <= 1'b0;
    end else begin
      sizeErr <= inValid && !busy && badSize;
      if (!busy) begin
        if (acceptOk) begin
          busy     <= 1'b1;
          stepQ    <= '0;
          lastIdxQ <= STEP_W'(inSize[4:2]) + STEP_W'(wantWb);
        end
      end else if (outReady) begin
        if (stepQ == lastIdxQ) busy <= 1'b0;
        else                   stepQ <= stepQ + 1'b1;
      end
    end
  end

  assign inReady     = !busy;
  assign outValid    = busy;
  assign ctl.capture = acceptOk;
  assign ctl.step    = stepQ;
  assign ctl.isLast  = (stepQ == lastIdxQ);
endmodule

// File: rtl/pair_cracker_dp.sv
module pair_cracker_dp
  import pair_cracker_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int IMM_W = 12,
  parameter int OFF_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_s                    ctl,
  input  logic [4:0]              inSize,
  input  logic                    inFp,
  input  logic                    inLoad,
  input  logic                    inSignExt,
  input  logic [1:0]              inMode,
  input  logic signed [IMM_W-1:0] inImm,
  input  logic [REG_W-1:0]        inBase,
  input  logic [REG_W-1:0]        inRegA,
  input  logic [REG_W-1:0]        inRegB,
  output logic [3:0]              outOp,
  output logic [REG_W-1:0]        outRegA,
  output logic [REG_W-1:0]        outRegB,
  output logic [OFF_W-1:0]        outOffset,
  output logic signed [IMM_W-1:0] outImm,
  output logic                    outFp,
  output logic                    outBaseSp,
  output logic                    outLast,
  output logic                    outDelayed
);
  localparam logic [REG_W-1:0] SP_IDX   = {REG_W{1'b1}};
  localparam int               HALF_OFF = 16;
  localparam int               WORD_OFF = 8;

  logic [2:0]              nMemQ;
  logic                    fpQ, loadQ, sextQ, postQ;
  logic signed [IMM_W-1:0] immQ;
  logic [REG_W-1:0]        baseQ, regAQ, regBQ;
  logic [STEP_W-1:0]       memIdx;
  uop_e                    op;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nMemQ <= '0; fpQ <= 1'b0; loadQ <= 1'b0; sextQ <= 1'b0; postQ <= 1'b0;
      immQ <= '0; baseQ <= '0; regAQ <= '0; regBQ <= '0;
    end else if (ctl.capture) begin
      nMemQ <= inSize[4:2];
      fpQ   <= inFp;
      loadQ <= inLoad;
      sextQ <= inSignExt;
      postQ <= (inMode == MODE_POST);
      immQ  <= inImm;
      baseQ <= inBase;
      regAQ <= inRegA;
      regBQ <= inRegB;
    end
  end

  assign memIdx = ctl.step - 1'b1;

  always_comb begin
    op        = OP_ADDR;
    outRegA   = baseQ;
    outRegB   = '0;
    outOffset = '0;
    outImm    = postQ ? '0 : immQ;
    outFp     = 1'b0;
    outBaseSp = (baseQ == SP_IDX);
    if (ctl.step != '0) begin
      if (memIdx < STEP_W'(nMemQ)) begin
        outImm    = '0;
        outFp     = fpQ;
        outBaseSp = 1'b0;
        case (nMemQ)
          3'd4: begin
            if (loadQ) op = memIdx[0] ? OP_LOAD_HI : OP_LOAD_LO;
            else       op = memIdx[0] ? OP_STORE_HI : OP_STORE_LO;
            outRegA   = memIdx[1] ? regBQ : regAQ;
            outOffset = memIdx[1] ? OFF_W'(HALF_OFF) : '0;
          end
          3'd2: begin
            op        = loadQ ? OP_LOAD : OP_STORE;
            outRegA   = memIdx[0] ? regBQ : regAQ;
            outOffset = memIdx[0] ? OFF_W'(WORD_OFF) : '0;
          end
          default: begin
            if (!loadQ)            op = OP_STORE2;
            else if (sextQ && !fpQ) op = OP_LOAD2_SX;
            else                   op = OP_LOAD2_ZX;
            outRegA = regAQ;
            outRegB = regBQ;
          end
        endcase
      end else begin
        op     = OP_WB;
        outImm = postQ ? immQ : '0;
      end
    end
  end

  assign outOp      = op;
  assign outLast    = ctl.isLast;
  assign outDelayed = !ctl.isLast;
endmodule

// File: rtl/pair_cracker.sv
module pair_cracker
  import pair_cracker_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int IMM_W = 12,
  parameter int OFF_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [4:0]              inSize,
  input  logic                    inFp,
  input  logic                    inLoad,
  input  logic                    inSignExt,
  input  logic [1:0]              inMode,
  input  logic signed [IMM_W-1:0] inImm,
  input  logic [REG_W-1:0]        inBase,
  input  logic [REG_W-1:0]        inRegA,
  input  logic [REG_W-1:0]        inRegB,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [3:0]              outOp,
  output logic [REG_W-1:0]        outRegA,
  output logic [REG_W-1:0]        outRegB,
  output logic [OFF_W-1:0]        outOffset,
  output logic signed [IMM_W-1:0] outImm,
  output logic                    outFp,
  output logic                    outBaseSp,
  output logic                    outLast,
  output logic                    outDelayed,
  output logic                    sizeErr
);
  ctl_s ctl;

  pair_cracker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSize(inSize),
    .inMode(inMode), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .sizeErr(sizeErr), .ctl(ctl)
  );

  pair_cracker_dp #(.REG_W(REG_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inSize(inSize), .inFp(inFp),
    .inLoad(inLoad), .inSignExt(inSignExt), .inMode(inMode), .inImm(inImm),
    .inBase(inBase), .inRegA(inRegA), .inRegB(inRegB), .outOp(outOp),
    .outRegA(outRegA), .outRegB(outRegB), .outOffset(outOffset),
    .outImm(outImm), .outFp(outFp), .outBaseSp(outBaseSp),
    .outLast(outLast), .outDelayed(outDelayed)
  );
endmodule

// File: rtl/pair_cracker_chk.sv
module pair_cracker_chk #(
  parameter int REG_W = 5,
  parameter int IMM_W = 12,
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [3:0]       outOp,
  input logic [REG_W-1:0] outRegA,
  input logic [REG_W-1:0] outRegB,
  input logic [OFF_W-1:0] outOffset,
  input logic [IMM_W-1:0] outImm,
  input logic             outFp,
  input logic             outLast,
  input logic             outDelayed,
  input logic             sizeErr
);
  // R1: no acceptance while a sequence is in flight
  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R3: every sequence opens with address generation
  p_first_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outOp == 4'd0);

  // R8: exactly one of last / delayed on a valid micro-op
  p_last_xor_delayed_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLast != outDelayed));

  // R2: the sequence ends after the last handshake
  p_drain_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid);

  // R10: outputs hold under backpressure
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid &&
      $stable({outOp, outRegA, outRegB, outOffset, outImm, outFp, outLast}));

  // R11: an error never coincides with a micro-op
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    sizeErr |-> !outValid);

  // R11: the error flag lasts one cycle when no new request follows
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    sizeErr && !inValid |=> !sizeErr);
endmodule

bind pair_cracker pair_cracker_chk #(.REG_W(REG_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outOp(outOp),
  .outRegA(outRegA), .outRegB(outRegB), .outOffset(outOffset),
  .outImm(outImm), .outFp(outFp), .outLast(outLast),
  .outDelayed(outDelayed), .sizeErr(sizeErr)
);

// File: tb/sim_pair_cracker.sv
`timescale 1ns/100ps
module sim_pair_cracker;
  localparam int REG_W = 5;
  localparam int IMM_W = 12;
  localparam int OFF_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inFp = 1'b0, inLoad = 1'b0, inSignExt = 1'b0;
  logic [4:0] inSize = '0;
  logic [1:0] inMode = '0;
  logic signed [IMM_W-1:0] inImm = '0;
  logic [REG_W-1:0] inBase = '0, inRegA = '0, inRegB = '0;
  logic outReady = 1'b1;
  logic inReady, outValid, outFp, outBaseSp, outLast, outDelayed, sizeErr;
  logic [3:0] outOp;
  logic [REG_W-1:0] outRegA, outRegB;
  logic [OFF_W-1:0] outOffset;
  logic signed [IMM_W-1:0] outImm;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pair_cracker #(.REG_W(REG_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSize(inSize), .inFp(inFp), .inLoad(inLoad), .inSignExt(inSignExt),
    .inMode(inMode), .inImm(inImm), .inBase(inBase), .inRegA(inRegA),
    .inRegB(inRegB), .outValid(outValid), .outReady(outReady),
    .outOp(outOp), .outRegA(outRegA), .outRegB(outRegB),
    .outOffset(outOffset), .outImm(outImm), .outFp(outFp),
    .outBaseSp(outBaseSp), .outLast(outLast), .outDelayed(outDelayed),
    .sizeErr(sizeErr)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // packed {op, regA, regB, offset, imm, fp}
  function automatic logic [34:0] expVec(input int s, input int size, input bit fp,
      input bit ld, input bit sx, input int mode, input logic [IMM_W-1:0] imm,
      input int base, input int ra, input int rb);
    int nMem = size / 4;
    bit post = (mode == 2);
    int op = 0, a = base, b = 0, off = 0, k = s - 1;
    logic [IMM_W-1:0] im = post ? '0 : imm;
    bit f = 0;
    if (s > 0 && s <= nMem) begin
      im = '0; f = fp;
      if (size == 16) begin
        op  = ld ? (k % 2 ? 4 : 3) : (k % 2 ? 6 : 5);
        a   = (k < 2) ? ra : rb;
        off = (k < 2) ? 0 : 16;
      end else if (size == 8) begin
        op = ld ? 1 : 2; a = (k == 0) ? ra : rb; off = k * 8;
      end else begin
        op = ld ? ((sx && !fp) ? 7 : 8) : 9; a = ra; b = rb;
      end
    end else if (s > nMem) begin
      op = 10; im = post ? imm : '0;
    end
    return {op[3:0], a[REG_W-1:0], b[REG_W-1:0], off[OFF_W-1:0], im, f};
  endfunction

  function automatic string tagOf(input int s, input int size);
    if (s == 0) return "R3";
    if (s > size / 4) return "R7";
    if (size == 16) return "R4";
    if (size == 8) return "R5";
    return "R6";
  endfunction

  task automatic runOne(input int size, input bit fp, input bit ld, input bit sx,
      input int mode, input logic signed [IMM_W-1:0] imm, input int base,
      input int ra, input int rb, input int stallPhase);
    int n = 1 + size / 4 + ((mode == 1 || mode == 2) ? 1 : 0);
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready when idle", inReady, 1);
    inSize = 5'(size); inFp = fp; inLoad = ld; inSignExt = sx;
    inMode = 2'(mode); inImm = imm; inBase = REG_W'(base);
    inRegA = REG_W'(ra); inRegB = REG_W'(rb); inValid = 1'b1;
    @(posedge clk); #1 inValid = 1'b0;
    check(outValid && !inReady, "R1 first micro-op next cycle", {outValid, inReady}, 2'b10);
    for (int s = 0; s < n; s++) begin
      logic [34:0] e = expVec(s, size, fp, ld, sx, mode, imm, base, ra, rb);
      logic [34:0] a;
      bit eSp = (s == 0 || s > size / 4) && (base == 31);
      @(negedge clk);
      a = {outOp, outRegA, outRegB, outOffset, outImm, outFp};
      check(outValid && a == e, {tagOf(s, size), "/R12 fields"}, a, e);
      check({outLast, outDelayed} == ((s == n - 1) ? 2'b10 : 2'b01), "R8 last/delayed",
            {outLast, outDelayed}, (s == n - 1) ? 2'b10 : 2'b01);
      check(outBaseSp == eSp, "R9 stack-pointer base", outBaseSp, eSp);
      if (((s + stallPhase) % 3) == 0) begin
        outReady = 1'b0;
        @(negedge clk);
        a = {outOp, outRegA, outRegB, outOffset, outImm, outFp};
        check(outValid && a == e && outLast == (s == n - 1), "R10 hold under stall", a, e);
        outReady = 1'b1;
      end
    end
    @(negedge clk);
    check(!outValid && inReady, "R2 count then drain", {outValid, inReady}, 2'b01);
  endtask

  task automatic runBad(input int size);
    @(negedge clk);
    inSize = 5'(size); inFp = 1'b0; inLoad = 1'b1; inMode = 2'd1; inValid = 1'b1;
    @(posedge clk); #1 inValid = 1'b0;
    check(sizeErr && !outValid && inReady, "R11 error flag, no micro-op",
          {sizeErr, outValid, inReady}, 3'b101);
    @(posedge clk); #1;
    check(!sizeErr && !outValid, "R11 flag lasts one cycle", {sizeErr, outValid}, 2'b00);
  endtask

  initial begin
    int iter = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!outValid && !sizeErr, "R1 reset state outputs", {outValid, sizeErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady, "R1 reset state ready", inReady, 1);
    for (int sz = 0; sz < 3; sz++)
      for (int fp = 0; fp < 2; fp++)
        for (int ld = 0; ld < 2; ld++)
          for (int sx = 0; sx < 2; sx++)
            for (int md = 0; md < 4; md++)
              for (int im = 0; im < 2; im++) begin
                runOne(4 << sz, fp[0], ld[0], sx[0], md,
                       im ? -12'sd24 : 12'sd40, (iter % 2) ? 31 : 7,
                       3 + iter % 5, 20 + iter % 7, iter % 4);
                iter++;
              end
    for (int b = 0; b < 32; b++)
      if (b != 4 && b != 8 && b != 16) runBad(b);
    runOne(16, 1'b1, 1'b0, 1'b0, 2, 12'sd2047, 31, 0, 31, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nErrors++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule